// File: doc/BRIEF.md
# Burst Gain Ramp Profiler

This stage shapes the start and end of a transmit burst. Both the in-phase and the quadrature sample streams are multiplied by the same coefficient, taken from a 128-word by 12-bit profile table. A pointer into the table moves only on cycles where the sample strobe is high. While transmit enable is high the pointer climbs toward a programmable length. While transmit enable is low it falls back to zero. The ramp-up and ramp-down envelopes are therefore mirror images of each other.

A host port writes and reads the table. A hold control freezes the applied gain and the pointer, so the table can be rewritten while the channel keeps running. When the profile is disabled, samples pass through at unity gain and the pointer is held at zero.

The pointer controller has five states:
- `ST_IDLE`: pointer at zero, transmit enable low.
- `ST_RISE`: climbing.
- `ST_PLAT`: pointer at or beyond the length, transmit enable high.
- `ST_FALL`: descending.
- `ST_FROZEN`: hold active.

Transitions:
- Any state goes to `ST_IDLE` when the profile is disabled (pointer cleared).
- Any state goes to `ST_FROZEN` when hold is set with the profile enabled.
- From `ST_IDLE`, `ST_RISE`, `ST_PLAT` or `ST_FALL`, a strobe steps the pointer and re-settles the state from transmit enable and the new pointer:
  - transmit enable high and pointer ≥ length gives `ST_PLAT`;
  - transmit enable high otherwise gives `ST_RISE`;
  - transmit enable low and pointer zero gives `ST_IDLE`;
  - transmit enable low otherwise gives `ST_FALL`.
- From `ST_FROZEN`, releasing hold settles the state by the same rule in that cycle. A strobe in that same cycle also steps the pointer.

Top module: `gain_ramp_shaper`

## Requirements
- R1: After reset, `out_vld` is low, `out_i` and `out_q` are zero, every table word reads zero, the pointer is zero and the held gain is unity (0x800).
- R2: A host write is stored only when the profile is disabled or hold is set; otherwise it leaves the table unchanged. `host_rd_data` shows the word at `host_addr` one clock later.
- R3: Coefficients are unsigned 12-bit with 0x800 = 1.0 and 0x001 = 2^-11. Each output is floor((x·g + 1024) / 2048). The same g is used for the I lane and the Q lane of a sample.
- R4: Each product is saturated to the signed 16-bit range [-32768, 32767].
- R5: With the profile disabled, g = 0x800, so outputs equal inputs. The pointer is forced to zero, so the first strobe after enabling uses word 0.
- R6: On a strobe with transmit enable high (profile enabled, no hold), the word at the current pointer is applied, then the pointer increments if it is below `prof_len`.
- R7: On a strobe with transmit enable low (profile enabled, no hold), the word at the current pointer is applied, then the pointer decrements if it is above zero.
- R8: A transmit-enable change in mid-ramp reverses direction from the current pointer value, without restarting.
- R9: While hold is set with the profile enabled, the gain most recently applied is reused and the pointer does not move.
- R10: `out_vld` is high exactly one clock after each `smp_stb` cycle. Without a strobe, neither the outputs nor the pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_en | input | 1 | Profile enable; low gives unity gain and pointer zero |
| prof_hold | input | 1 | Freeze gain and pointer, open table for writes |
| prof_len | input | 7 | Top pointer value of the ramp |
| tx_en | input | 1 | Transmit enable, sets the ramp direction |
| smp_stb | input | 1 | Sample strobe |
| in_i | input | 16 | In-phase input sample, two's complement |
| in_q | input | 16 | Quadrature input sample, two's complement |
| host_wr_en | input | 1 | Host table write strobe |
| host_addr | input | 7 | Host table address for write and read |
| host_wr_data | input | 12 | Host write word |
| host_rd_data | output | 12 | Registered table word at `host_addr` |
| out_vld | output | 1 | Output sample valid |
| out_i | output | 16 | Scaled in-phase sample |
| out_q | output | 16 | Scaled quadrature sample |

## Verification
The assertions check the following on every cycle:
- the pointer moves by at most one step;
- the pointer is zero while disabled and whenever the controller is idle;
- the pointer stays still under hold or without a strobe;
- blocked host writes leave the table untouched;
- a non-negative input never yields a negative output;
- equal I and Q inputs give equal outputs;
- disabled passes samples unchanged;
- valid follows the strobe.

Only the bench scenarios can show that the right table word is applied at each step:
- the exact rise and fall sequences;
- the turn-around point of a reversed ramp;
- the held gain staying in use while the table is rewritten;
- the rounding and saturation values.

// File: rtl/gr_pkg.sv
package gr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RISE,
        ST_PLAT,
        ST_FALL,
        ST_FROZEN
    } ramp_st_t;
endpackage

// File: rtl/gr_profile_mem.sv
module gr_profile_mem #(
    parameter int AW = 7,
    parameter int GW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_ok,
    input  logic [AW-1:0] addr,
    input  logic [GW-1:0] wr_data,
    output logic [GW-1:0] rd_data,
    input  logic [AW-1:0] coef_addr,
    output logic [GW-1:0] coef
);
    localparam int DEPTH = 1 << AW;

    logic [GW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (wr_en && wr_ok) begin
            mem_q[addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem_q[addr];
    end

    assign coef = mem_q[coef_addr];

    // Checker state: remember a refused write and the word it targeted.
    logic [AW-1:0] chk_addr;
    logic [GW-1:0] chk_old;
    logic          chk_blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_addr <= '0;
            chk_old  <= '0;
            chk_blk  <= 1'b0;
        end else begin
            chk_addr <= addr;
            chk_old  <= mem_q[addr];
            chk_blk  <= wr_en && !wr_ok;
        end
    end

    p_wr_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_blk |-> mem_q[chk_addr] == chk_old);
endmodule

// File: rtl/gr_ramp_fsm.sv
module gr_ramp_fsm
    import gr_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hold,
    input  logic          tx,
    input  logic          stb,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] ptr
);
    ramp_st_t      st_q, st_d;
    logic [AW-1:0] ptr_q, ptr_d, ptr_step;

    function automatic ramp_st_t settle(input logic t, input logic [AW-1:0] p,
                                        input logic [AW-1:0] l);
        if (t) return (p >= l) ? ST_PLAT : ST_RISE;
        return (p == '0) ? ST_IDLE : ST_FALL;
    endfunction

    // One-step move of the pointer in the direction set by tx.
    always_comb begin
        if (tx) ptr_step = (ptr_q < len) ? ptr_q + 1'b1 : ptr_q;
        else    ptr_step = (ptr_q != '0) ? ptr_q - 1'b1 : ptr_q;
    end

    always_comb begin
        st_d  = st_q;
        ptr_d = ptr_q;
        if (!en) begin
            st_d  = ST_IDLE;
            ptr_d = '0;
        end else if (hold) begin
            st_d = ST_FROZEN;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_RISE, ST_PLAT, ST_FALL: begin
                    if (stb) begin
                        ptr_d = ptr_step;
                        st_d  = settle(tx, ptr_step, len);
                    end
                end
                ST_FROZEN: begin
                    if (stb) ptr_d = ptr_step;
                    st_d = settle(tx, ptr_d, len);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

    p_dis_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ptr_q == '0);
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en && hold |=> $stable(ptr_q));
    p_no_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en && !stb |=> $stable(ptr_q));
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_IDLE |-> ptr_q == '0);
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q != $past(ptr_q) |->
            (ptr_q == $past(ptr_q) + 1'b1) || (ptr_q + 1'b1 == $past(ptr_q)) || (ptr_q == '0));
endmodule

// File: rtl/gr_lane_scale.sv
module gr_lane_scale #(
    parameter int DW = 16,
    parameter int GW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic signed [DW-1:0] x,
    input  logic        [GW-1:0] g,
    output logic signed [DW-1:0] y
);
    localparam int PW   = DW + GW + 1;
    localparam int FRAC = GW - 1;
    localparam int SW   = PW - FRAC;
    localparam int RNDV = 1 << (FRAC - 1);
    localparam logic signed [SW-1:0] HI = SW'((1 << (DW - 1)) - 1);
    localparam logic signed [SW-1:0] LO = -HI - SW'(1);

    logic signed [PW-1:0] xe, ge, prod, rnd;
    logic signed [SW-1:0] sh;
    logic signed [DW-1:0] y_d;

    assign xe   = PW'(x);
    assign ge   = PW'($signed({1'b0, g}));
    assign prod = xe * ge;
    assign rnd  = prod + PW'(RNDV);
    assign sh   = rnd[PW-1:FRAC];

    always_comb begin
        if (sh > HI)      y_d = {1'b0, {(DW-1){1'b1}}};
        else if (sh < LO) y_d = {1'b1, {(DW-1){1'b0}}};
        else              y_d = sh[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   y <= '0;
        else if (stb) y <= y_d;
    end

    p_sign_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb && !x[DW-1] |=> !y[DW-1]);
endmodule

// File: rtl/gain_ramp_shaper.sv
module gain_ramp_shaper #(
    parameter int DW = 16,
    parameter int GW = 12,
    parameter int AW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prof_en,
    input  logic                 prof_hold,
    input  logic        [AW-1:0] prof_len,
    input  logic                 tx_en,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic                 host_wr_en,
    input  logic        [AW-1:0] host_addr,
    input  logic        [GW-1:0] host_wr_data,
    output logic        [GW-1:0] host_rd_data,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int NL = 2;
    localparam logic [GW-1:0] UNITY = GW'(1) << (GW - 1);

    logic [AW-1:0] ptr;
    logic [GW-1:0] coef, g_sel, gain_q;
    logic          frozen;

    assign frozen = prof_en && prof_hold;

    gr_profile_mem #(.AW(AW), .GW(GW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en),
        .wr_ok    (!prof_en || prof_hold),
        .addr     (host_addr),
        .wr_data  (host_wr_data),
        .rd_data  (host_rd_data),
        .coef_addr(ptr),
        .coef     (coef)
    );

    gr_ramp_fsm #(.AW(AW)) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (prof_en),
        .hold (prof_hold),
        .tx   (tx_en),
        .stb  (smp_stb),
        .len  (prof_len),
        .ptr  (ptr)
    );

    always_comb begin
        if (!prof_en)    g_sel = UNITY;
        else if (frozen) g_sel = gain_q;
        else             g_sel = coef;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q  <= UNITY;
            out_vld <= 1'b0;
        end else begin
            out_vld <= smp_stb;
            if (smp_stb && !frozen) gain_q <= g_sel;
        end
    end

    logic signed [DW-1:0] lane_x [NL];
    logic signed [DW-1:0] lane_y [NL];

    assign lane_x[0] = in_i;
    assign lane_x[1] = in_q;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        gr_lane_scale #(.DW(DW), .GW(GW)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .stb  (smp_stb),
            .x    (lane_x[k]),
            .g    (g_sel),
            .y    (lane_y[k])
        );
    end

    assign out_i = lane_y[0];
    assign out_q = lane_y[1];

    p_vld_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> out_vld);
    p_vld_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> !out_vld && $stable(out_i) && $stable(out_q));
    p_unity_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && !prof_en |=> out_i == $past(in_i) && out_q == $past(in_q));
    p_lane_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && in_i == in_q |=> out_i == out_q);
endmodule

// File: tb/tb_gain_ramp_shaper.sv
`timescale 1ns/1ps
module tb_gain_ramp_shaper;
    localparam int DW = 16;
    localparam int GW = 12;
    localparam int AW = 7;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prof_en = 1'b0, prof_hold = 1'b0, tx_en = 1'b0, smp_stb = 1'b0;
    logic [AW-1:0] prof_len = '0;
    logic signed [DW-1:0] in_i = '0, in_q = '0;
    logic host_wr_en = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [GW-1:0] host_wr_data = '0;
    logic [GW-1:0] host_rd_data;
    logic out_vld;
    logic signed [DW-1:0] out_i, out_q;

    always #4 clk = ~clk;

    gain_ramp_shaper #(.DW(DW), .GW(GW), .AW(AW)) dut (.*);

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [GW-1:0] m_mem [DEPTH];
    int            m_ptr = 0;
    logic [GW-1:0] m_gq = 12'h800;

    logic signed [DW-1:0] exp_i_q [$];
    logic signed [DW-1:0] exp_q_q [$];
    string                tag_q   [$];

    function automatic logic signed [DW-1:0] scale(input int x, input int g);
        longint p;
        p = longint'(x) * longint'(g) + 1024;
        p = p >>> 11;
        if (p > 32767)  p = 32767;
        if (p < -32768) p = -32768;
        return p[DW-1:0];
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: one strobe, expected result pushed to the scoreboard.
    task automatic send(input int xi, input int xq, input string tag);
        logic [GW-1:0] g;
        @(negedge clk);
        if (!prof_en) begin
            g = 12'h800;
            m_ptr = 0;
        end else if (prof_hold) begin
            g = m_gq;
        end else begin
            g = m_mem[m_ptr];
            if (tx_en) begin
                if (m_ptr < int'(prof_len)) m_ptr++;
            end else if (m_ptr > 0) begin
                m_ptr--;
            end
        end
        if (!(prof_en && prof_hold)) m_gq = g;
        in_i = DW'(xi);
        in_q = DW'(xq);
        exp_i_q.push_back(scale(xi, int'(g)));
        exp_q_q.push_back(scale(xq, int'(g)));
        tag_q.push_back(tag);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic hwrite(input int a, input int d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr = AW'(a);
        host_wr_data = GW'(d);
        if (!prof_en || prof_hold) m_mem[a] = GW'(d);
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hread(input int a, input string tag);
        @(negedge clk);
        host_addr = AW'(a);
        @(negedge clk);
        check(tag, longint'(host_rd_data), longint'(m_mem[a]));
    endtask

    // Monitor: compare every valid output against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_i_q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL R10 unexpected valid: actual 1 expected 0");
            end else begin
                automatic logic signed [DW-1:0] ei = exp_i_q.pop_front();
                automatic logic signed [DW-1:0] eq = exp_q_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({t, " I"}, longint'(out_i), longint'(ei));
                check({t, " Q"}, longint'(out_q), longint'(eq));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 vld", longint'(out_vld), 0);
        check("R1 out_i", longint'(out_i), 0);
        check("R1 out_q", longint'(out_q), 0);
        rst_n = 1'b1;
        hread(5, "R1 table zero");

        // R5 disabled passes at unity
        send(100, -200, "R5 unity");
        send(32767, -32768, "R5 unity ext");
        send(0, 1, "R5 unity small");

        // R2 table load while disabled
        for (int a = 0; a < DEPTH; a++) hwrite(a, a * 32 + 5);
        hread(0, "R2 read 0");
        hread(127, "R2 read 127");

        // R6 ramp up with length 5
        prof_len = 7'd5;
        prof_en = 1'b1;
        tx_en = 1'b1;
        for (int k = 0; k < 8; k++) send(1000 + k * 300, -700 - k * 90, "R6 rise");
        // R7 ramp down
        tx_en = 1'b0;
        for (int k = 0; k < 8; k++) send(-2000 + k * 512, 1500, "R7 fall");

        // R8 reversal mid-ramp
        tx_en = 1'b1;
        for (int k = 0; k < 3; k++) send(4000, 4000, "R8 up part");
        tx_en = 1'b0;
        for (int k = 0; k < 2; k++) send(-4000, 2500, "R8 turn down");
        tx_en = 1'b1;
        for (int k = 0; k < 2; k++) send(12345, -12345, "R8 turn up");

        // R2 live write ignored
        hwrite(2, 12'hABC);
        hread(2, "R2 live write ignored");

        // R9 hold: gain frozen, table writable
        prof_hold = 1'b1;
        send(20000, -20000, "R9 held gain");
        send(-9, 31, "R9 held gain");
        hwrite(3, 12'hFFF);
        hwrite(4, 12'h400);
        hread(3, "R9 write under hold");
        send(32767, -32768, "R9 held after rewrite");
        prof_hold = 1'b0;

        // R4 saturation with gain 0xFFF, R3 rounding with 0x400
        send(32767, -32768, "R4 saturate");
        send(3, -3, "R3 round");
        send(-1, 1, "R3 plateau");

        // R10 no strobe, no change
        tx_en = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check("R10 quiet vld", longint'(out_vld), 0);
        end
        send(700, 700, "R10 pointer kept");
        send(700, -700, "R10 next step");

        // R5 enable clears pointer
        prof_en = 1'b0;
        m_ptr = 0;
        repeat (2) @(negedge clk);
        prof_en = 1'b1;
        tx_en = 1'b1;
        send(5000, -5000, "R5 restart at word 0");
        send(5000, -5000, "R6 restart step");

        repeat (3) @(negedge clk);
        check("R10 queue drained", longint'(exp_i_q.size()), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule